// File: doc/BRIEF.md
# PRBS31 Bit Error Rate Checker

This block sits behind a serial receiver and measures the bit error rate of a link that carries a PRBS31 test stream. Received bytes arrive one at a time with a strobe. The block packs them into 32-bit words in a selectable byte order. It uses the first complete word after arming to seed a local 31-bit Galois generator, so it locks onto a transmitter that may already be partway through its sequence. Each later word is XORed with the locally predicted word, and the set bits of that mask are counted by a two-stage parallel (SWAR) reduction.

Three saturating counters are exposed: the octets that were compared, the bit errors found, and the whole seconds since lock, taken from an external one-second tick. The error rate is errors divided by eight times octets. Software or a wider system does that division. A start pulse arms the first lock. A clear pulse drops lock, zeroes every counter and arms a fresh lock without a new start.

Top module: `prbs31_ber_checker`

## Requirements
- R1: After reset, `synced` is 0 and `octet_count`, `error_count` and `sync_seconds` are all 0. Reset asserts asynchronously and is released inside the block through a two-flop synchronizer.
- R2: While the checker is idle (after reset and before the first `start` pulse), received bytes are ignored, including a byte in the same cycle as `start`. A `start` pulse arms the lock step.
- R3: With `msb_first` = 0, the first byte of each group of four lands in bits 7:0 of the word and the fourth in bits 31:24. With `msb_first` = 1, the first byte lands in bits 31:24 and the fourth in bits 7:0.
- R4: Once armed, the first complete word W is not compared or counted. The local generator is loaded with ~W[30:0], and `synced` goes to 1.
- R5: A candidate seed word whose bits 30:0 are all ones would lock the generator at zero. Such a word is rejected: `synced` stays 0, and the next complete word is tried as the seed.
- R6: Once synced, the generator steps once per word as s' = {0, s[30:1]} XOR (s[0] ? 0x48000000 : 0), and the expected word is ~{0, s'}. `error_count` grows by the number of ones in (received XOR expected) over all 32 bits, and the update is visible within 6 cycles of the word's last byte.
- R7: `octet_count` grows by 4 for every word compared. Seed and rejected words are not counted, and neither are bytes of an unfinished word.
- R8: `sync_seconds` grows by 1 for each `tick_1s` cycle while `synced` is 1. It stays 0 while `synced` is 0.
- R9: A `clear` pulse drops `synced`, zeroes all three counters, discards any partial word and in-flight comparison, and arms a new lock with no `start` needed. `clear` takes priority over a byte or `start` in the same cycle.
- R10: All three counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe, one byte per high cycle |
| rx_byte | input | 8 | Received byte |
| msb_first | input | 1 | Byte order: 1 places the first byte in the top of the word |
| clear | input | 1 | Drop lock, zero counters, re-arm |
| start | input | 1 | Arm the first lock from idle |
| tick_1s | input | 1 | One-cycle pulse per elapsed second |
| synced | output | 1 | Local generator is locked to the stream |
| octet_count | output | CNT_W (64) | Octets compared since lock |
| error_count | output | CNT_W (64) | Bit errors found since lock |
| sync_seconds | output | SEC_W (32) | Seconds elapsed while locked |

## Verification
The bench goes after the following corner cases, each named with the fault it would expose:
- Flips in bit 31 and bit 0. A checker that left the always-one top bit out of the comparison, or misaligned the mask, would under-count these.
- An all-ones candidate seed. A design without the guard would lock to the zero state and report a burst of errors on every word.
- Words sent in the wrong byte order. A swapped packer would show up as a large and exactly predictable error count, or as errors on a clean stream.
- Counting against a narrow second instance. A wrapping counter would return small values where 63 is expected.
- A clear issued between runs. A checker that kept the old seed or stale pipeline contents would count errors from a stream it no longer follows.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int WORD_W         = 32;
  localparam int LFSR_W         = WORD_W - 1;
  localparam int BYTE_W         = 8;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int LANE_W         = $clog2(BYTES_PER_WORD);
  localparam int POP_W          = $clog2(WORD_W) + 1;

  // Feedback taps of x^31 + x^28 + 1 in right-shifting Galois form
  localparam logic [LFSR_W-1:0] TAP_MASK = 31'h4800_0000;
  localparam logic [LFSR_W-1:0] LFSR_IV  = 31'h0000_0001;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEED  = 2'd1,
    ST_CHECK = 2'd2
  } chk_state_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? TAP_MASK : '0);
  endfunction

endpackage

// File: rtl/prbs_byte_packer.sv
module prbs_byte_packer
  import prbs_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              msb_first,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_out
);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] shifted;
  logic              last_byte;

  assign shifted   = msb_first ? {shreg_q[WORD_W-BYTE_W-1:0], byte_in}
                               : {byte_in, shreg_q[WORD_W-1:BYTE_W]};
  assign last_byte = byte_vld && (lane_q == LANE_W'(BYTES_PER_WORD - 1));

  always_comb begin
    lane_d  = lane_q;
    shreg_d = shreg_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    if (flush) begin
      lane_d = '0;
    end else if (byte_vld) begin
      shreg_d = shifted;
      lane_d  = last_byte ? '0 : lane_q + 1'b1;
      if (last_byte) begin
        word_d = shifted;
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      shreg_q <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      lane_q  <= lane_d;
      vld_q   <= vld_d;
      if (byte_vld) shreg_q <= shreg_d;
      if (last_byte) word_q <= word_d;
    end
  end

  assign word_vld = vld_q;
  assign word_out = word_q;

  AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (lane_q == '0)); // R3

  AST_WORD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(byte_vld)); // R3

endmodule

// File: rtl/prbs31_local_gen.sv
module prbs31_local_gen
  import prbs_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              advance,
  output logic [WORD_W-1:0] expect_word
);

  logic [LFSR_W-1:0] state_q, state_d;
  logic [LFSR_W-1:0] state_nx;
  logic              state_en;

  assign state_nx = lfsr_step(state_q);
  assign state_en = load || advance;

  always_comb begin
    state_d = state_q;
    if (load)         state_d = seed;
    else if (advance) state_d = state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= LFSR_IV;
    else if (state_en) state_q <= state_d;
  end

  // Transmitter emits the complemented state, top bit held at zero
  assign expect_word = ~{1'b0, state_nx};

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R5

  AST_GEN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (state_q != $past(state_q))); // R6

endmodule

// File: rtl/swar_popcount.sv
module swar_popcount
  import prbs_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_mask,
  output logic              out_vld,
  output logic [POP_W-1:0]  out_cnt
);

  localparam logic [WORD_W-1:0] M_PAIR   = 32'h5555_5555;
  localparam logic [WORD_W-1:0] M_QUAD   = 32'h3333_3333;
  localparam logic [WORD_W-1:0] M_NIBBLE = 32'h0F0F_0F0F;

  logic [WORD_W-1:0] pair_sum, quad_sum, nib_sum;
  logic [WORD_W-1:0] quad_q;
  logic              vld1_q, vld2_q;
  logic [POP_W-1:0]  byte_total;
  logic [POP_W-1:0]  cnt_q;

  // Stage 1: 2-bit then 4-bit partial sums
  always_comb begin
    pair_sum = in_mask - ((in_mask >> 1) & M_PAIR);
    quad_sum = (pair_sum & M_QUAD) + ((pair_sum >> 2) & M_QUAD);
  end

  // Stage 2: 8-bit partial sums, then fold the byte lanes
  always_comb begin
    nib_sum    = (quad_q + (quad_q >> 4)) & M_NIBBLE;
    byte_total = '0;
    for (int i = 0; i < BYTES_PER_WORD; i++) begin
      byte_total = byte_total + POP_W'(nib_sum[i*BYTE_W +: BYTE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q <= '0;
      vld1_q <= 1'b0;
      cnt_q  <= '0;
      vld2_q <= 1'b0;
    end else begin
      vld1_q <= in_vld && !flush;
      vld2_q <= vld1_q && !flush;
      if (in_vld) quad_q <= quad_sum;
      if (vld1_q) cnt_q  <= byte_total;
    end
  end

  assign out_vld = vld2_q;
  assign out_cnt = cnt_q;

  AST_POP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !flush && in_mask == '0) |=> ##1 (out_cnt == '0)); // R6

  AST_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !flush && in_mask == '1) |=> ##1 (out_cnt == POP_W'(WORD_W))); // R6

endmodule

// File: rtl/prbs31_ber_checker.sv
module prbs31_ber_checker
  import prbs_chk_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             msb_first,
  input  logic             clear,
  input  logic             start,
  input  logic             tick_1s,
  output logic             synced,
  output logic [CNT_W-1:0] octet_count,
  output logic [CNT_W-1:0] error_count,
  output logic [SEC_W-1:0] sync_seconds
);

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  chk_state_e        state_q, state_d;
  logic              byte_en;
  logic              word_vld;
  logic [WORD_W-1:0] word_rx;
  logic              seed_ok;
  logic              gen_load, gen_adv;
  logic [WORD_W-1:0] word_exp;
  logic [WORD_W-1:0] mask_q, mask_d;
  logic              mask_vld_q;
  logic              pop_vld;
  logic [POP_W-1:0]  pop_cnt;

  logic [CNT_W-1:0]  oct_q, oct_d, err_q, err_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [CNT_W:0]    oct_sum, err_sum;
  logic [SEC_W:0]    sec_sum;

  assign byte_en  = rx_valid && (state_q != ST_IDLE) && !clear;
  assign seed_ok  = word_vld && (word_rx[LFSR_W-1:0] != '1);
  assign gen_load = (state_q == ST_SEED) && seed_ok && !clear;
  assign gen_adv  = (state_q == ST_CHECK) && word_vld && !clear;

  prbs_byte_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .flush     (clear),
    .byte_vld  (byte_en),
    .byte_in   (rx_byte),
    .msb_first (msb_first),
    .word_vld  (word_vld),
    .word_out  (word_rx)
  );

  prbs31_local_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .load        (gen_load),
    .seed        (~word_rx[LFSR_W-1:0]),
    .advance     (gen_adv),
    .expect_word (word_exp)
  );

  // Lock state machine
  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = ST_SEED;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start)    state_d = ST_SEED;
        ST_SEED:  if (gen_load) state_d = ST_CHECK;
        ST_CHECK: state_d = ST_CHECK;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // Comparison stage
  assign mask_d = word_rx ^ word_exp;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mask_q     <= '0;
      mask_vld_q <= 1'b0;
    end else begin
      mask_vld_q <= gen_adv;
      if (gen_adv) mask_q <= mask_d;
    end
  end

  swar_popcount u_pop (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .flush   (clear),
    .in_vld  (mask_vld_q && !clear),
    .in_mask (mask_q),
    .out_vld (pop_vld),
    .out_cnt (pop_cnt)
  );

  // Saturating counters
  assign oct_sum = {1'b0, oct_q} + (CNT_W+1)'(BYTES_PER_WORD);
  assign err_sum = {1'b0, err_q} + (CNT_W+1)'(pop_cnt);
  assign sec_sum = {1'b0, sec_q} + (SEC_W+1)'(1);

  always_comb begin
    oct_d = oct_q;
    err_d = err_q;
    sec_d = sec_q;
    if (clear) begin
      oct_d = '0;
      err_d = '0;
      sec_d = '0;
    end else begin
      if (mask_vld_q) oct_d = oct_sum[CNT_W] ? '1 : oct_sum[CNT_W-1:0];
      if (pop_vld)    err_d = err_sum[CNT_W] ? '1 : err_sum[CNT_W-1:0];
      if (tick_1s && state_q == ST_CHECK)
        sec_d = sec_sum[SEC_W] ? '1 : sec_sum[SEC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      oct_q <= '0;
      err_q <= '0;
      sec_q <= '0;
    end else begin
      oct_q <= oct_d;
      err_q <= err_d;
      sec_q <= sec_d;
    end
  end

  assign synced       = (state_q == ST_CHECK);
  assign octet_count  = oct_q;
  assign error_count  = err_q;
  assign sync_seconds = sec_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear |=> (!synced && octet_count == '0 && error_count == '0 && sync_seconds == '0)); // R9

  AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clear |=> (error_count >= $past(error_count))); // R10

  AST_OCTET_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clear |=> (octet_count == $past(octet_count) ||
                octet_count == $past(octet_count) + CNT_W'(BYTES_PER_WORD) ||
                octet_count == '1)); // R7

  AST_SEC_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_q_n)
    !synced |-> (sync_seconds == '0)); // R8

  AST_NO_IDLE_WORDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_IDLE) |-> !word_vld); // R2

endmodule

// File: tb/prbs31_ber_checker_test.sv
module prbs31_ber_checker_test;

  logic        clk;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        msb_first;
  logic        clear;
  logic        start;
  logic        tick_1s;

  logic        synced;
  logic [63:0] octet_count, error_count;
  logic [31:0] sync_seconds;
  logic        s_synced;
  logic [5:0]  s_oct, s_err;
  logic [31:0] s_sec;

  int n_checks, n_fail;
  bit done;
  logic [30:0] tx_state;
  logic [63:0] exp_err, exp_oct;

  prbs31_ber_checker uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .msb_first(msb_first), .clear(clear), .start(start), .tick_1s(tick_1s),
    .synced(synced), .octet_count(octet_count), .error_count(error_count),
    .sync_seconds(sync_seconds)
  );

  prbs31_ber_checker #(.CNT_W(6), .SEC_W(32)) uut_sat (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .msb_first(msb_first), .clear(clear), .start(start), .tick_1s(tick_1s),
    .synced(s_synced), .octet_count(s_oct), .error_count(s_err),
    .sync_seconds(s_sec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [30:0] f_step(input logic [30:0] s);
    logic [30:0] t;
    t = s >> 1;
    if (s[0]) begin
      t[30] = ~t[30];
      t[27] = ~t[27];
    end
    return t;
  endfunction

  function automatic int f_pop(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] f_swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // Next word of the transmitter's stream
  function automatic logic [31:0] f_next_word();
    tx_state = f_step(tx_state);
    return ~{1'b0, tx_state};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input logic msb);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = msb ? w[31-8*i -: 8] : w[8*i +: 8];
      @(negedge clk);
      rx_valid = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_err = 0;
    exp_oct = 0;
  endtask

  task automatic send_checked(input logic [31:0] flips, input logic msb);
    logic [31:0] w;
    w = f_next_word();
    send_word(w ^ flips, msb);
    exp_err += 64'(f_pop(flips));
    exp_oct += 4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd4711));
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 0; rx_valid = 0; rx_byte = 0; msb_first = 0;
    clear = 0; start = 0; tick_1s = 0;
    tx_state = 31'h1;
    exp_err = 0; exp_oct = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "synced", 64'(synced), 0);
    check("R1", "octets", octet_count, 0);
    check("R1", "errors", error_count, 0);
    check("R1", "seconds", 64'(sync_seconds), 0);

    // R2 idle ignores bytes and ticks
    send_word(f_next_word(), 1'b0);
    send_word(f_next_word() ^ 32'hFF, 1'b0);
    @(negedge clk); tick_1s = 1; @(negedge clk); tick_1s = 0;
    settle();
    check("R2", "synced while idle", 64'(synced), 0);
    check("R2", "octets while idle", octet_count, 0);
    check("R8", "seconds before lock", 64'(sync_seconds), 0);

    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (5) void'(f_next_word());
    send_word(f_next_word(), 1'b0);       // seed word
    settle();
    check("R4", "synced after seed", 64'(synced), 1);
    check("R4", "seed not counted", octet_count, 0);

    for (int i = 0; i < 4; i++) send_checked(32'h0, 1'b0);
    settle();
    check("R7", "octets clean run", octet_count, exp_oct);
    check("R6", "errors clean run", error_count, exp_err);

    // R6 single flips at edge positions, incl. bit 31
    send_checked(32'h0000_0001, 1'b0);
    send_checked(32'h8000_0000, 1'b0);
    send_checked(32'h0000_8000, 1'b0);
    settle();
    check("R6", "single flips", error_count, exp_err);

    // R6 random sparse and dense masks
    for (int i = 0; i < 24; i++) begin
      logic [31:0] m;
      m = (i % 3 == 0) ? $urandom() : ($urandom() & $urandom() & $urandom());
      send_checked(m, 1'b0);
    end
    settle();
    check("R6", "random masks", error_count, exp_err);
    check("R7", "octets random run", octet_count, exp_oct);

    // R8 seconds while locked
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick_1s = 1; @(negedge clk); tick_1s = 0;
    end
    @(negedge clk);
    check("R8", "seconds", 64'(sync_seconds), 3);

    // R9 clear with a partial word in flight
    send_word(f_next_word(), 1'b0);
    @(negedge clk); rx_valid = 1; rx_byte = 8'hA5;
    @(negedge clk); rx_valid = 0;
    pulse_clear();
    @(negedge clk);
    check("R9", "synced after clear", 64'(synced), 0);
    check("R9", "errors after clear", error_count, 0);
    check("R9", "octets after clear", octet_count, 0);
    check("R9", "seconds after clear", 64'(sync_seconds), 0);

    // R3 msb-first order, re-armed without start (R9)
    msb_first = 1;
    send_word(f_next_word(), 1'b1);
    settle();
    check("R9", "relock without start", 64'(synced), 1);
    send_checked(32'h0100_0000, 1'b1);
    send_checked(32'h0, 1'b1);
    send_checked(32'h8000_0081, 1'b1);
    settle();
    check("R3", "msb-first errors", error_count, exp_err);
    w = f_next_word();
    send_word(w, 1'b0);                   // wrong order on purpose
    exp_err += 64'(f_pop(w ^ f_swap(w)));
    exp_oct += 4;
    settle();
    check("R3", "swapped order errors", error_count, exp_err);
    check("R7", "octets msb run", octet_count, exp_oct);

    // R5 all-ones seed rejected
    msb_first = 0;
    pulse_clear();
    send_word(32'hFFFF_FFFF, 1'b0);
    settle();
    check("R5", "all-ones seed", 64'(synced), 0);
    send_word(32'h7FFF_FFFF, 1'b0);
    settle();
    check("R5", "low-ones seed", 64'(synced), 0);
    send_word(f_next_word(), 1'b0);
    settle();
    check("R5", "next word seeds", 64'(synced), 1);
    send_checked(32'h0000_0010, 1'b0);
    settle();
    check("R5", "stream after rejection", error_count, exp_err);

    // R10 saturation on the narrow instance
    pulse_clear();
    send_word(f_next_word(), 1'b0);
    for (int i = 0; i < 3; i++) send_checked(32'hFFFF_FFFF, 1'b0);
    settle();
    check("R10", "wide errors", error_count, 96);
    check("R10", "narrow errors saturate", 64'(s_err), 63);
    for (int i = 0; i < 16; i++) send_checked(32'h0, 1'b0);
    settle();
    check("R10", "wide octets", octet_count, exp_oct);
    check("R10", "narrow octets saturate", 64'(s_oct), 63);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule